// File: doc/BRIEF.md
# Selectable Clock Divider Router

This block picks one of two reference clocks and sends it through a power-of-two reference divider whose output feeds the phase detector of an external jitter-cleaning loop. The same 3-bit code also has two rerouting values. One skips the first loop and feeds the selected reference straight into the external multiplier stage. The other skips both loops and feeds the selected reference straight into the output dividers. Two independent output dividers each take a 2-bit code that selects a ratio of 4, 8 or 32, or turns the output off.

All clock signals are modelled as levels sampled by a fast system clock `clk_i`. The outputs of the external loops, `vcxo_clk_i` and `mult_clk_i`, arrive as ordinary inputs. Every divider runs a free-running 5-bit counter of source rising edges. A divider output is one bit of that counter, which gives 50% duty. A new code is adopted only when the counter wraps, so a ratio change cannot produce a runt pulse.

Top module: `clk_div_router`

## Requirements
- R1: While `rst_ni` is low, `pd_ref_o`, `mult_in_o`, `qa_o`, `qa_oe_o`, `qb_o` and `qb_oe_o` are all 0.
- R2: `ref_sel_i` = 0 makes `ref0_i` the selected reference, and `ref_sel_i` = 1 makes `ref1_i` the selected reference.
- R3: Reference codes 0..5 (3'b000..3'b101) divide the selected reference by 2^code on `pd_ref_o`. For a code k of 1 or more, `pd_ref_o` is bit k-1 of n, where n is the number of rising edges of the selected reference since reset, modulo 32.
- R4: Reference code 6 (3'b110) holds `pd_ref_o` at 0 and routes the selected reference to `mult_in_o`. Under every other active code, `mult_in_o` follows `vcxo_clk_i`.
- R5: Reference code 7 (3'b111) holds `pd_ref_o` at 0 and makes the selected reference the source of both output dividers. Under every other active code, that source is `mult_clk_i`.
- R6: Output code 2'b00 drives the enable low and the data output to 0.
- R7: Output codes 2'b01, 2'b10 and 2'b11 divide the output source by 32, 8 and 4, with the enable high. For a ratio of 2^k, the data is bit k-1 of the count of source rising edges since reset, modulo 32.
- R8: Output A uses only `qa_code_i` and output B uses only `qb_code_i`. Each keeps its own counter and its own active code.
- R9: Each divider adopts a new code only on the source rising edge that takes its 5-bit counter from 31 to 0. The exception is the first `clk_i` edge after reset, which adopts the code directly. The active reference code also governs the routing of R4 and R5, and routing follows the active code as it stands before each edge.
- R10: All outputs are registered. A source level sampled at one `clk_i` edge shows on the outputs from that edge onward. With reference code 0, `pd_ref_o` repeats the selected reference one cycle late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref0_i | input | 1 | Reference clock 0 (level) |
| ref1_i | input | 1 | Reference clock 1 (level) |
| ref_sel_i | input | 1 | Reference select |
| ref_code_i | input | 3 | Reference ratio / bypass code |
| vcxo_clk_i | input | 1 | Output of the external first loop |
| mult_clk_i | input | 1 | Output of the external multiplier loop |
| qa_code_i | input | 2 | Output A ratio / off code |
| qb_code_i | input | 2 | Output B ratio / off code |
| pd_ref_o | output | 1 | Divided reference to the phase detector |
| mult_in_o | output | 1 | Input clock of the multiplier stage |
| qa_o | output | 1 | Output A data |
| qa_oe_o | output | 1 | Output A enable |
| qb_o | output | 1 | Output B data |
| qb_oe_o | output | 1 | Output B enable |

## Verification
The bench sweeps every combination of reference select, reference code and the two output codes. The four clock inputs toggle at different rates, so a routing mistake changes the observed waveform. A design that applies a code change at once rather than at the wrap shows a different phase or ratio in the cycles before the wrap. The same happens with an off-by-one wrap point. A design that routes by the new code and not the active one puts the wrong clock on `mult_in_o` or on the outputs for up to a full counter period. Swapped decode entries, such as dividing by 4 for code 2'b01 or leaving data live in the off state, show up as a ratio or enable mismatch against the arithmetic edge-count model.

// File: rtl/clk_router_pkg.sv
package clk_router_pkg;
  localparam int SHIFT_W    = 3;
  localparam int REF_CODE_W = 3;
  localparam int OUT_CODE_W = 2;

  typedef enum logic [1:0] {
    RT_NORMAL    = 2'd0,
    RT_SKIP_VCXO = 2'd1,
    RT_SKIP_BOTH = 2'd2
  } route_e;

  typedef struct packed {
    logic               en;
    logic [SHIFT_W-1:0] shift;
    route_e             route;
  } div_cfg_t;

  function automatic div_cfg_t ref_decode(input logic [REF_CODE_W-1:0] code);
    div_cfg_t c;
    c = '{en: 1'b1, shift: code, route: RT_NORMAL};
    if (code == 3'd6) c = '{en: 1'b0, shift: '0, route: RT_SKIP_VCXO};
    if (code == 3'd7) c = '{en: 1'b0, shift: '0, route: RT_SKIP_BOTH};
    return c;
  endfunction

  function automatic div_cfg_t out_decode(input logic [OUT_CODE_W-1:0] code);
    div_cfg_t c;
    unique case (code)
      2'b01:   c = '{en: 1'b1, shift: 3'd5, route: RT_NORMAL};
      2'b10:   c = '{en: 1'b1, shift: 3'd3, route: RT_NORMAL};
      2'b11:   c = '{en: 1'b1, shift: 3'd2, route: RT_NORMAL};
      default: c = '{en: 1'b0, shift: 3'd0, route: RT_NORMAL};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/clk_div_pow2.sv
module clk_div_pow2
  import clk_router_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     src_i,
  input  div_cfg_t cfg_i,
  output div_cfg_t cfg_o,
  output logic     load_o,
  output logic     div_o
);
  logic             src_q, armed_q, rise, wrap, tap;
  logic [CNT_W-1:0] cnt_q;
  div_cfg_t         cfg_q;

  assign rise   = src_i & ~src_q;
  assign wrap   = rise & (&cnt_q);
  // first edge after reset adopts the code directly
  assign load_o = ~armed_q | wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      cfg_q   <= '{en: 1'b0, shift: '0, route: RT_NORMAL};
    end else begin
      src_q <= src_i;
      if (rise) cnt_q <= cnt_q + 1'b1;
      if (load_o) begin
        cfg_q   <= cfg_i;
        armed_q <= 1'b1;
      end
    end
  end

  always_comb begin
    tap = src_q;
    for (int i = 0; i < CNT_W; i++)
      if (cfg_q.shift == SHIFT_W'(i + 1)) tap = cnt_q[i];
  end

  assign div_o = cfg_q.en & tap;
  assign cfg_o = cfg_q;
endmodule

// File: rtl/clk_route.sv
module clk_route
  import clk_router_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  route_e route_i,
  input  logic   ref_src_i,
  input  logic   vcxo_i,
  input  logic   mult_i,
  output logic   mult_in_o,
  output logic   out_src_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mult_in_o <= 1'b0;
    else         mult_in_o <= (route_i == RT_SKIP_VCXO) ? ref_src_i : vcxo_i;
  end

  assign out_src_o = (route_i == RT_SKIP_BOTH) ? ref_src_i : mult_i;
endmodule

// File: rtl/clk_div_router.sv
module clk_div_router
  import clk_router_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ref0_i,
  input  logic                  ref1_i,
  input  logic                  ref_sel_i,
  input  logic [REF_CODE_W-1:0] ref_code_i,
  input  logic                  vcxo_clk_i,
  input  logic                  mult_clk_i,
  input  logic [OUT_CODE_W-1:0] qa_code_i,
  input  logic [OUT_CODE_W-1:0] qb_code_i,
  output logic                  pd_ref_o,
  output logic                  mult_in_o,
  output logic                  qa_o,
  output logic                  qa_oe_o,
  output logic                  qb_o,
  output logic                  qb_oe_o
);
  localparam int N_OUT = 2;

  logic     ref_src, out_src, ref_load;
  div_cfg_t ref_cfg;
  logic [N_OUT-1:0][OUT_CODE_W-1:0] out_code;
  div_cfg_t [N_OUT-1:0] out_cfg;
  logic [N_OUT-1:0]     out_data, out_load;

  assign ref_src  = ref_sel_i ? ref1_i : ref0_i;
  assign out_code = {qb_code_i, qa_code_i};

  clk_div_pow2 #(.CNT_W(DIV_W)) u_ref_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (ref_src),
    .cfg_i  (ref_decode(ref_code_i)),
    .cfg_o  (ref_cfg),
    .load_o (ref_load),
    .div_o  (pd_ref_o)
  );

  clk_route u_route (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .route_i   (ref_cfg.route),
    .ref_src_i (ref_src),
    .vcxo_i    (vcxo_clk_i),
    .mult_i    (mult_clk_i),
    .mult_in_o (mult_in_o),
    .out_src_o (out_src)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    clk_div_pow2 #(.CNT_W(DIV_W)) u_out_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (out_src),
      .cfg_i  (out_decode(out_code[g])),
      .cfg_o  (out_cfg[g]),
      .load_o (out_load[g]),
      .div_o  (out_data[g])
    );
  end

  assign qa_o    = out_data[0];
  assign qa_oe_o = out_cfg[0].en;
  assign qb_o    = out_data[1];
  assign qb_oe_o = out_cfg[1].en;
endmodule

// File: rtl/clk_div_router_chk.sv
module clk_div_router_chk
  import clk_router_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ref_src,
  input div_cfg_t             ref_cfg,
  input logic                 ref_load,
  input div_cfg_t [1:0]       out_cfg,
  input logic [1:0]           out_load,
  input logic                 pd_ref_o,
  input logic                 mult_in_o,
  input logic                 qa_o,
  input logic                 qa_oe_o,
  input logic                 qb_o,
  input logic                 qb_oe_o
);
  p_hiz_qa_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qa_oe_o |-> !qa_o);
  p_hiz_qb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qb_oe_o |-> !qb_o);
  p_ref_cfg_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ref_cfg) |-> $past(ref_load));
  p_qa_cfg_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_cfg[0]) |-> $past(out_load[0]));
  p_qb_cfg_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_cfg[1]) |-> $past(out_load[1]));
  p_div1_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_cfg.en && ref_cfg.shift == '0) |-> (pd_ref_o == $past(ref_src)));
  p_skip_vcxo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ref_cfg.route == RT_SKIP_VCXO) |-> (mult_in_o == $past(ref_src)));
  p_ref_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ref_cfg.route == RT_SKIP_BOTH) && (ref_cfg.route == RT_SKIP_BOTH) |-> !pd_ref_o);
endmodule

bind clk_div_router clk_div_router_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ref_src   (ref_src),
  .ref_cfg   (ref_cfg),
  .ref_load  (ref_load),
  .out_cfg   (out_cfg),
  .out_load  (out_load),
  .pd_ref_o  (pd_ref_o),
  .mult_in_o (mult_in_o),
  .qa_o      (qa_o),
  .qa_oe_o   (qa_oe_o),
  .qb_o      (qb_o),
  .qb_oe_o   (qb_oe_o)
);

// File: tb/clk_div_router_tb.sv
`timescale 1ns/1ps
module clk_div_router_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ref0_i = 0, ref1_i = 0, ref_sel_i = 0, vcxo_clk_i = 0, mult_clk_i = 0;
  logic [2:0] ref_code_i = 3'd0;
  logic [1:0] qa_code_i = 2'd0, qb_code_i = 2'd0;
  logic pd_ref_o, mult_in_o, qa_o, qa_oe_o, qb_o, qb_oe_o;

  always #4 clk_i = ~clk_i;

  clk_div_router u_dut (.*);

  int n_chk = 0, n_fail = 0, tc = 0;
  bit done = 0;

  // model state: 0 = reference divider, 1 = output A, 2 = output B
  int m_n[3];
  int m_code[3];
  bit m_armed[3];
  bit m_prev[3];

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0b exp=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int shift_of(input int idx, input int code);
    if (idx == 0) return (code <= 5) ? code : -1;
    case (code)
      1: return 5;
      2: return 3;
      3: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic bit exp_data(input int idx);
    int sh;
    if (!m_armed[idx]) return 1'b0;
    sh = shift_of(idx, m_code[idx]);
    if (sh < 0) return 1'b0;
    if (sh == 0) return m_prev[idx];
    return 1'(m_n[idx] >> (sh - 1));
  endfunction

  function automatic bit exp_en(input int idx);
    return m_armed[idx] && (shift_of(idx, m_code[idx]) >= 0);
  endfunction

  task automatic mstep(input int idx, input bit lvl, input int code);
    bit rise;
    rise = lvl && !m_prev[idx];
    if (!m_armed[idx] || (rise && m_n[idx] == 31)) begin
      m_code[idx]  = code;
      m_armed[idx] = 1'b1;
    end
    if (rise) m_n[idx] = (m_n[idx] + 1) % 32;
    m_prev[idx] = lvl;
  endtask

  function automatic string ref_tag();
    if (int'(ref_code_i) != m_code[0]) return "R9";
    case (m_code[0])
      0: return "R10";
      6: return "R4";
      7: return "R5";
      default: return ref_sel_i ? "R2" : "R3";
    endcase
  endfunction

  function automatic string out_tag(input int idx, input int drv);
    if (drv != m_code[idx]) return "R9";
    if (m_code[idx] == 0) return "R6";
    return (idx == 1) ? "R7" : "R8";
  endfunction

  task automatic step();
    bit sel_l, osrc, e_mult;
    tc++;
    ref0_i     = 1'(tc % 2);
    ref1_i     = 1'((tc / 3) % 2);
    vcxo_clk_i = 1'((tc / 2) % 2);
    mult_clk_i = 1'((tc / 5) % 2);
    sel_l  = ref_sel_i ? ref1_i : ref0_i;
    // routing follows the active code held before this edge
    e_mult = (m_armed[0] && m_code[0] == 6) ? sel_l : vcxo_clk_i;
    osrc   = (m_armed[0] && m_code[0] == 7) ? sel_l : mult_clk_i;
    mstep(0, sel_l, int'(ref_code_i));
    mstep(1, osrc, int'(qa_code_i));
    mstep(2, osrc, int'(qb_code_i));
    @(posedge clk_i);
    @(negedge clk_i);
    chk(ref_tag(), "pd_ref_o", pd_ref_o, exp_data(0));
    chk((m_code[0] == 6) ? "R4" : "R5", "mult_in_o", mult_in_o, e_mult);
    chk(out_tag(1, int'(qa_code_i)), "qa_o", qa_o, exp_data(1));
    chk(out_tag(1, int'(qa_code_i)), "qa_oe_o", qa_oe_o, exp_en(1));
    chk(out_tag(2, int'(qb_code_i)), "qb_o", qb_o, exp_data(2));
    chk(out_tag(2, int'(qb_code_i)), "qb_oe_o", qb_oe_o, exp_en(2));
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      m_n[i] = 0; m_code[i] = 0; m_armed[i] = 0; m_prev[i] = 0;
    end
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", "pd_ref_o", pd_ref_o, 1'b0);
    chk("R1", "mult_in_o", mult_in_o, 1'b0);
    chk("R1", "qa_o", qa_o, 1'b0);
    chk("R1", "qa_oe_o", qa_oe_o, 1'b0);
    chk("R1", "qb_o", qb_o, 1'b0);
    chk("R1", "qb_oe_o", qb_oe_o, 1'b0);
    rst_ni = 1'b1;
    for (int rs = 0; rs < 2; rs++)
      for (int rc = 0; rc < 8; rc++)
        for (int oc = 0; oc < 16; oc++) begin
          ref_sel_i  = 1'(rs);
          ref_code_i = 3'(rc);
          qa_code_i  = 2'(oc % 4);
          qb_code_i  = 2'(oc / 4);
          repeat (330) step();
        end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule